// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block is a watchdog timer that is always running: there is no enable input and no way to stop it once reset is released. A down-counter is loaded from a timeout value and decrements on every clock of the slow clock it runs on. Software keeps the system alive by writing a key word on a reload strobe. If the counter reaches zero without such a write, the block escalates in two steps.

The first expiry raises an interrupt and reloads the counter on its own, which gives software one more full period to respond. If a second expiry follows with no valid reload in between, the block drives a system reset request pulse of fixed length. It then starts over in its first stage. The timeout register is read only when a valid reload is accepted. The value captured then is used for every automatic reload until the next valid reload.

The reload strobe is a plain control input and not a stream. It is accepted in the cycle it is seen, so there is no ready signal and no back-pressure. The interrupt and the reset request are level outputs.

Top module: `wdog_escalator`

## Requirements
- R1: Once reset is released, the counter holds RESET_TIMEOUT, both irq and rst_req are low, and counting starts at once with no enable. With nothing written, irq rises RESET_TIMEOUT+1 clocks after release.
- R2: The counter decrements once per clock. An expiry happens on the clock edge at which the counter is zero, so after a load of T the expiry comes T+1 clocks later.
- R3: On an expiry in the first stage, irq is set, the stage advances to the second stage, and the counter reloads with the captured timeout.
- R4: On an expiry in the second stage, rst_req is raised, the stage returns to the first stage, and the counter reloads with the captured timeout. With no writes at all, the second expiries therefore fall every 2T+2 clocks.
- R5: rst_req stays high for exactly RST_CYCLES clocks (default 4) after a second-stage expiry. Another second-stage expiry during the pulse restarts the full length.
- R6: A valid reload is reload_wr high with reload_data equal to KEY. It loads the counter with timeout_val, clears irq and returns the stage to the first stage, so the next expiry is again a first expiry.
- R7: A reload_wr with any reload_data other than KEY has no effect: the expiry timing, irq and rst_req behave as if no write had happened.
- R8: timeout_val is captured only on a valid reload. Changing it at any other time alters neither the count in progress nor the automatic reloads.
- R9: irq stays high until irq_clr or a valid reload. irq_clr does not change the stage. If irq_clr arrives in the same cycle as a first-stage expiry, irq ends up set.
- R10: A valid reload in the same cycle as an expiry wins: no irq is set, no rst_req is started, and the new count begins from timeout_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload_wr | input | 1 | Reload write strobe, one cycle per write |
| reload_data | input | KEY_W | Data written with the strobe; only KEY reloads |
| timeout_val | input | CNT_W | Timeout register value, captured on a valid reload |
| irq_clr | input | 1 | Clears the interrupt without touching the stage |
| irq | output | 1 | First-stage expiry interrupt, held until cleared |
| rst_req | output | 1 | System reset request pulse, RST_CYCLES long |

## Verification
Two pairs of events can land on the same clock edge. A key write can coincide with an expiry, and an interrupt clear can coincide with a first-stage expiry. The bench lines up each pair by putting the write or the clear on the exact edge where, by arithmetic, the counter hits zero. It then judges the outcome from the ports: after a reload that collides with an expiry, irq and rst_req stay low and the next expiry falls a full T+1 later; after a clear that collides with an expiry, irq is left set. Sweeps over several short timeouts check every cycle against the closed-form expiry schedule, so a reload that loses the collision, or a clear that wins it, moves an edge the bench predicts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    STG_ARMED  = 1'b0,
    STG_WARNED = 1'b1
  } wdog_stage_e;
endpackage

// File: rtl/wdog_key_check.sv
module wdog_key_check #(
  parameter int          KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'h5A3C
) (
  input  logic             wr,
  input  logic [KEY_W-1:0] data,
  output logic             accept
);
  // Only the exact key word counts as a service write (R6, R7).
  always_comb accept = wr && (data == KEY);
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int               CNT_W     = 16,
  parameter logic [CNT_W-1:0] RESET_VAL = 16'd1023
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_load,
  input  logic [CNT_W-1:0] sw_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lat;

  // A software load overrides the expiry of the same cycle (R10).
  always_comb expire = (cnt == '0) && !sw_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RESET_VAL;
      lat <= RESET_VAL;
    end else if (sw_load) begin
      cnt <= sw_val;
      lat <= sw_val;
    end else if (cnt == '0) begin
      cnt <= lat;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  p_count_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_load && cnt != '0) |=> cnt == $past(cnt) - ONE);
  p_auto_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == $past(lat));
  p_sample_at_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> (cnt == $past(sw_val)) && (lat == $past(sw_val)));
  p_lat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_load |=> $stable(lat));
endmodule

// File: rtl/wdog_stage_ctrl.sv
module wdog_stage_ctrl
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        expire,
  input  logic        sw_reload,
  input  logic        irq_clr,
  output logic        irq,
  output logic        second_hit,
  output wdog_stage_e stage
);
  always_comb second_hit = expire && (stage == STG_WARNED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= STG_ARMED;
      irq   <= 1'b0;
    end else begin
      if (sw_reload)
        stage <= STG_ARMED;
      else if (expire)
        stage <= (stage == STG_ARMED) ? STG_WARNED : STG_ARMED;

      // Setting by a first expiry beats a clear in the same cycle (R9).
      if (expire && stage == STG_ARMED)
        irq <= 1'b1;
      else if (sw_reload || irq_clr)
        irq <= 1'b0;
    end
  end

  p_first_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && stage == STG_ARMED) |=> irq && stage == STG_WARNED);
  p_reload_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reload |=> !irq && stage == STG_ARMED);
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && !sw_reload) |=> irq);
  p_clr_keeps_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !sw_reload && !expire) |=> $stable(stage));
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic rst_req
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain <= '0;
    else if (trigger)
      remain <= LEN;
    else if (remain != '0)
      remain <= remain - ONE;
  end

  always_comb rst_req = (remain != '0);

  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> rst_req && remain == LEN);
  p_pulse_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trigger && remain == ONE) |=> !rst_req);
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
  parameter int                CNT_W         = 16,
  parameter int                KEY_W         = 16,
  parameter logic [KEY_W-1:0]  KEY           = 16'h5A3C,
  parameter logic [CNT_W-1:0]  RESET_TIMEOUT = 16'd1023,
  parameter int                RST_CYCLES    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_wr,
  input  logic [KEY_W-1:0] reload_data,
  input  logic [CNT_W-1:0] timeout_val,
  input  logic             irq_clr,
  output logic             irq,
  output logic             rst_req
);
  import wdog_pkg::*;

  logic        accept;
  logic        expire;
  logic        second_hit;
  wdog_stage_e stage;

  wdog_key_check #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
    .wr     (reload_wr),
    .data   (reload_data),
    .accept (accept)
  );

  wdog_down_counter #(.CNT_W(CNT_W), .RESET_VAL(RESET_TIMEOUT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_load (accept),
    .sw_val  (timeout_val),
    .expire  (expire)
  );

  wdog_stage_ctrl u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .sw_reload  (accept),
    .irq_clr    (irq_clr),
    .irq        (irq),
    .second_hit (second_hit),
    .stage      (stage)
  );

  wdog_rst_pulse #(.PULSE_LEN(RST_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (second_hit),
    .rst_req (rst_req)
  );

  p_rst_on_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    second_hit |=> rst_req && stage == STG_ARMED);
  p_bad_key_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_wr && reload_data != KEY && !expire && !irq_clr) |=> $stable(irq));
  p_reload_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !$rose(rst_req) && !$rose(irq));
endmodule

// File: tb/wdog_escalator_tb.sv
module wdog_escalator_tb;
  localparam int              CW  = 8;
  localparam int              KW  = 16;
  localparam logic [KW-1:0]   KEY = 16'h5A3C;
  localparam int              RT  = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reload_wr;
  logic [KW-1:0] reload_data;
  logic [CW-1:0] timeout_val;
  logic          irq_clr;
  logic          irq;
  logic          rst_req;
  int            n_chk = 0;
  int            n_bad = 0;

  always #10 clk = ~clk;

  wdog_escalator #(.CNT_W(CW), .KEY_W(KW), .KEY(KEY),
                   .RESET_TIMEOUT(CW'(RT)), .RST_CYCLES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reload_wr(reload_wr), .reload_data(reload_data),
    .timeout_val(timeout_val), .irq_clr(irq_clr), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reload(input logic [KW-1:0] key, input int t);
    reload_data = key;
    timeout_val = CW'(t);
    reload_wr   = 1'b1;
    tick();
    reload_wr   = 1'b0;
  endtask

  task automatic settle();
    do_reload(KEY, 30);
    repeat (6) tick();
  endtask

  // Second-stage expiries fall at m*(2t+2); each opens a 4-cycle pulse.
  function automatic logic exp_rst(input int k, input int t);
    for (int m = 1; m * (2 * t + 2) <= k; m++)
      if (k <= m * (2 * t + 2) + 3) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reload_wr = 1'b0; reload_data = '0; timeout_val = '0; irq_clr = 1'b0;
    repeat (3) tick();
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 rst_req in reset", rst_req, 1'b0);
    rst_n = 1'b1;
    // R1: free running from release with the reset timeout
    for (int k = 1; k <= 4 * RT + 8; k++) begin
      tick();
      chk("R1 irq after release", irq, k >= RT + 1);
      chk("R1 rst_req after release", rst_req, exp_rst(k, RT));
    end

    // R2 R3 R4 R5: sweep of short timeouts, no service
    for (int t = 0; t <= 6; t++) begin
      settle();
      do_reload(KEY, t);
      chk("R6 irq cleared by reload", irq, 1'b0);
      for (int k = 1; k <= 4 * t + 8; k++) begin
        tick();
        chk("R2 R3 irq schedule", irq, k >= t + 1);
        chk("R4 R5 rst_req schedule", rst_req, exp_rst(k, t));
      end
    end

    // R7: wrong key before and after the first expiry
    settle();
    do_reload(KEY, 4);
    for (int k = 1; k <= 12; k++) begin
      if (k == 2 || k == 6) begin
        reload_data = 16'h1234; timeout_val = 8'd50; reload_wr = 1'b1;
      end
      tick();
      reload_wr = 1'b0;
      chk("R7 irq unaffected by bad key", irq, k >= 5);
      chk("R7 rst_req unaffected by bad key", rst_req, exp_rst(k, 4));
    end

    // R8: timeout changed without reload has no effect
    settle();
    do_reload(KEY, 3);
    timeout_val = 8'd9;
    for (int k = 1; k <= 14; k++) begin
      tick();
      chk("R8 irq uses captured timeout", irq, k >= 4);
      chk("R8 rst_req uses captured timeout", rst_req, exp_rst(k, 3));
    end

    // R6: reload after the first expiry restores the first stage
    settle();
    do_reload(KEY, 3);
    for (int k = 1; k <= 14; k++) begin
      if (k == 5) begin
        reload_data = KEY; timeout_val = 8'd3; reload_wr = 1'b1;
      end
      tick();
      reload_wr = 1'b0;
      chk("R6 irq after reload", irq, (k == 4) || (k >= 9));
      chk("R6 no reset after reload", rst_req, (k >= 13));
    end

    // R9: clear leaves stage; clear loses against a first expiry
    settle();
    do_reload(KEY, 3);
    for (int k = 1; k <= 12; k++) begin
      if (k == 5 || k == 12) irq_clr = 1'b1;
      tick();
      irq_clr = 1'b0;
      chk("R9 irq clear and set-wins", irq, (k == 4) || (k >= 12));
      chk("R9 stage kept across clear", rst_req, (k >= 8) && (k <= 11));
    end

    // R10: key write on the exact expiry edge, first and second stage
    settle();
    do_reload(KEY, 3);
    for (int k = 1; k <= 13; k++) begin
      if (k == 4) begin
        reload_data = KEY; timeout_val = 8'd3; reload_wr = 1'b1;
      end
      tick();
      reload_wr = 1'b0;
      chk("R10 reload beats first expiry irq", irq, k >= 8);
      chk("R10 reload beats first expiry rst", rst_req, k >= 12);
    end
    settle();
    do_reload(KEY, 3);
    for (int k = 1; k <= 13; k++) begin
      if (k == 8) begin
        reload_data = KEY; timeout_val = 8'd3; reload_wr = 1'b1;
      end
      tick();
      reload_wr = 1'b0;
      chk("R10 reload beats second expiry irq", irq, (k >= 4 && k <= 7) || k >= 12);
      chk("R10 reload beats second expiry rst", rst_req, 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule